// File: doc/BRIEF.md
# Clock Output Mode and Test-Divide Stage

This block is the last stage in front of a bank of clock output pins. It takes the functional clock levels for seven output groups and sends them to one registered data bit and one output-enable bit for each pin. A two-bit function select picks one of three behaviours for the whole bank. In normal operation each pin follows its group source, gated by its own enable bit, by the stop requests and by power-down. In high-impedance mode every pin is released. In test mode each pin carries an external test clock divided by a fixed ratio for its group.

The output groups are laid out low to high in the output vector: processor clocks, stoppable bus clocks, one free-running bus clock, memory clocks, one serial-bus clock, graphics-port clocks and one reference clock. The test clock is sampled in the system clock domain. Its rising edges drive a single two-bit counter, so the half-rate and quarter-rate copies always change on the same test-clock edge. The stop and power-down requests may arrive at any time, and each one passes through a two-flop synchronizer.

Top module: `clkout_stage`

## Requirements
- R1: Function select 11 drives every `clk_oe` bit to 0 and every `clk_out` bit to 0 on the next clock, whatever the enables, stops, power-down and the frequency select input.
- R2: Function select 01 with `sel1` = 0 is test mode: processor, memory, serial-bus and graphics-port outputs carry `tclk` divided by 2.
- R3: In test mode both kinds of bus output (stoppable and free-running) carry `tclk` divided by 4.
- R4: In test mode the reference output carries `tclk` undivided.
- R5: Function select 01 with `sel1` = 1 behaves exactly as normal operation.
- R6: Function select 10 behaves exactly as normal operation (00).
- R7: In normal operation every `clk_oe` bit is 1, and an output whose `en` bit is 0 is driven low. It is not released.
- R8: In normal operation `stop_cpu` = 1 forces the processor outputs low. `stop_pci` = 1 forces the stoppable bus outputs low but leaves the free-running bus output running.
- R9: In normal operation `pdn` = 1 forces every output low while `clk_oe` stays 1.
- R10: In test mode the divide-by-4 output changes only on cycles where the divide-by-2 output also changes. The enables, stops and power-down have no effect in test mode.
- R11: While `rst` is high, `clk_out` and `clk_oe` are all 0.
- R12: In normal operation `clk_out` follows `src_clk` one clock later. A change of `stop_cpu`, `stop_pci` or `pdn` reaches `clk_out` three clocks later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| fsel | input | 2 | Function select: 00/10 normal, 01 test, 11 high impedance |
| sel1 | input | 1 | Frequency select bit; a value of 1 blocks test mode |
| en | input | N_OUT | Per-output enable bits, order CPU, PCI, PCI-free, SDRAM, USB, AGP, REF |
| stop_cpu | input | 1 | Asynchronous request to hold processor clocks low |
| stop_pci | input | 1 | Asynchronous request to hold stoppable bus clocks low |
| pdn | input | 1 | Asynchronous power-down request, all outputs low |
| src_clk | input | 7 | Functional clock level per group, bit 0 CPU through bit 6 REF |
| tclk | input | 1 | External test clock |
| clk_out | output | N_OUT | Registered output levels |
| clk_oe | output | N_OUT | Registered output enables (0 = high impedance) |

## Verification
A table of static patterns holds every source high and then sweeps the function select, the frequency select bit, the stop and power-down combinations and the sparse enable masks. These patterns separate the two normal-mode codes from the test and high-impedance codes, and processor stopping from bus stopping. They also show that the free-running bus clock ignores the bus stop. A second phase runs the test clock with every enable cleared and every stop raised. It counts rising edges on each group's output over 48 test periods, which tells the three divide ratios apart and shows that the gating is ignored. A directed step on one group source checks the one-cycle path. A check during reset confirms that the bank starts released and low.

// File: rtl/clkout_pkg.sv
package clkout_pkg;

  localparam int NGRP = 7;

  typedef enum logic [2:0] {
    G_CPU  = 3'd0,
    G_PCI  = 3'd1,
    G_PCIF = 3'd2,
    G_SDR  = 3'd3,
    G_USB  = 3'd4,
    G_AGP  = 3'd5,
    G_REF  = 3'd6
  } grp_e;

  typedef enum logic [1:0] {
    M_NORM = 2'd0,
    M_TEST = 2'd1,
    M_HIZ  = 2'd2
  } mode_e;

  // Group owning output index idx, groups laid out low to high.
  function automatic int grp_of(int idx, int nc, int np, int ns, int na);
    int b;
    b = nc;
    if (idx < b) return int'(G_CPU);
    b += np;
    if (idx < b) return int'(G_PCI);
    b += 1;
    if (idx < b) return int'(G_PCIF);
    b += ns;
    if (idx < b) return int'(G_SDR);
    b += 1;
    if (idx < b) return int'(G_USB);
    b += na;
    if (idx < b) return int'(G_AGP);
    return int'(G_REF);
  endfunction

  // Index into the test tap vector {div4, div2, div1}.
  function automatic int tap_of(int grp);
    case (grp)
      int'(G_PCI), int'(G_PCIF): return 2;
      int'(G_REF):               return 0;
      default:                   return 1;
    endcase
  endfunction

  function automatic mode_e decode_mode(logic [1:0] fs, logic s1);
    if (fs == 2'b11)              return M_HIZ;
    if (fs == 2'b01 && !s1)       return M_TEST;
    return M_NORM;
  endfunction

endpackage

// File: rtl/clkout_sync.sv
module clkout_sync #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= '0;
      q  <= '0;
    end else begin
      s1 <= d;
      q  <= s1;
    end
  end
endmodule

// File: rtl/clkout_tdiv.sv
module clkout_tdiv #(
  parameter int CW = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       run,
  input  logic       tclk,
  output logic [2:0] taps
);
  logic          t1, t2;
  logic [CW-1:0] cnt;
  logic          rise;

  assign rise = t1 & ~t2;

  always_ff @(posedge clk) begin
    if (rst) begin
      t1 <= 1'b0;
      t2 <= 1'b0;
    end else begin
      t1 <= tclk;
      t2 <= t1;
    end
  end

  // One counter feeds both ratios, so they stay phase aligned.
  always_ff @(posedge clk) begin
    if (rst || !run)
      cnt <= '0;
    else if (rise)
      cnt <= cnt + 1'b1;
  end

  assign taps = {cnt[1], cnt[0], t1};
endmodule

// File: rtl/clkout_lane.sv
module clkout_lane #(
  parameter int TAP = 1
) (
  input  logic               clk,
  input  logic               rst,
  input  clkout_pkg::mode_e  mode,
  input  logic               src,
  input  logic               en,
  input  logic               stop,
  input  logic [2:0]         taps,
  output logic               o,
  output logic               oe
);
  always_ff @(posedge clk) begin
    if (rst) begin
      o  <= 1'b0;
      oe <= 1'b0;
    end else begin
      case (mode)
        clkout_pkg::M_HIZ: begin
          o  <= 1'b0;
          oe <= 1'b0;
        end
        clkout_pkg::M_TEST: begin
          o  <= taps[TAP];
          oe <= 1'b1;
        end
        default: begin
          o  <= src & en & ~stop;
          oe <= 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/clkout_stage.sv
module clkout_stage #(
  parameter int N_CPU = 4,
  parameter int N_PCI = 4,
  parameter int N_SDR = 12,
  parameter int N_AGP = 2,
  localparam int N_OUT = N_CPU + N_PCI + N_SDR + N_AGP + 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       fsel,
  input  logic             sel1,
  input  logic [N_OUT-1:0] en,
  input  logic             stop_cpu,
  input  logic             stop_pci,
  input  logic             pdn,
  input  logic [6:0]       src_clk,
  input  logic             tclk,
  output logic [N_OUT-1:0] clk_out,
  output logic [N_OUT-1:0] clk_oe
);
  import clkout_pkg::*;

  mode_e                mode;
  logic [2:0]           ctl_s;
  logic [2:0]           taps;
  logic [NGRP-1:0]      grp_stop;

  assign mode = decode_mode(fsel, sel1);

  clkout_sync #(.W(3)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({pdn, stop_pci, stop_cpu}),
    .q   (ctl_s)
  );

  clkout_tdiv #(.CW(2)) u_tdiv (
    .clk  (clk),
    .rst  (rst),
    .run  (mode == M_TEST),
    .tclk (tclk),
    .taps (taps)
  );

  always_comb begin
    grp_stop = {NGRP{ctl_s[2]}};
    grp_stop[G_CPU] = ctl_s[2] | ctl_s[0];
    grp_stop[G_PCI] = ctl_s[2] | ctl_s[1];
  end

  for (genvar gi = 0; gi < N_OUT; gi++) begin : g_lane
    localparam int GRP = grp_of(gi, N_CPU, N_PCI, N_SDR, N_AGP);
    clkout_lane #(.TAP(tap_of(GRP))) u_lane (
      .clk  (clk),
      .rst  (rst),
      .mode (mode),
      .src  (src_clk[GRP]),
      .en   (en[gi]),
      .stop (grp_stop[GRP]),
      .taps (taps),
      .o    (clk_out[gi]),
      .oe   (clk_oe[gi])
    );
  end
endmodule

// File: rtl/clkout_stage_chk.sv
module clkout_stage_chk #(
  parameter int N_CPU = 4,
  parameter int N_PCI = 4,
  parameter int N_SDR = 12,
  parameter int N_AGP = 2,
  localparam int N_OUT = N_CPU + N_PCI + N_SDR + N_AGP + 3
) (
  input logic             clk,
  input logic             rst,
  input logic [1:0]       fsel,
  input logic             sel1,
  input logic [N_OUT-1:0] en,
  input logic             stop_cpu,
  input logic             pdn,
  input logic [N_OUT-1:0] clk_out,
  input logic [N_OUT-1:0] clk_oe
);
  logic [2:0] cyc;
  logic [1:0] tcyc;
  logic       tmode, nmode;

  assign tmode = (fsel == 2'b01) && !sel1;
  assign nmode = (fsel[0] == 1'b0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cyc  <= '0;
      tcyc <= '0;
    end else begin
      if (cyc != 3'd7) cyc <= cyc + 1'b1;
      if (!tmode) tcyc <= '0;
      else if (tcyc != 2'd3) tcyc <= tcyc + 1'b1;
    end
  end

  assert_hiz_R1: assert property (@(posedge clk) disable iff (rst)
    (fsel == 2'b11) |=> (clk_oe == '0 && clk_out == '0));

  assert_oe_on_R7: assert property (@(posedge clk) disable iff (rst)
    (fsel != 2'b11) |=> (clk_oe == '1));

  for (genvar i = 0; i < N_OUT; i++) begin : g_en
    assert_dis_low_R7: assert property (@(posedge clk) disable iff (rst)
      (nmode && !en[i]) |=> !clk_out[i]);
  end

  assert_pdn_R9: assert property (@(posedge clk) disable iff (rst)
    (cyc >= 3'd4 && nmode && pdn && $past(pdn) && $past(pdn, 2))
      |=> (clk_out == '0));

  assert_stop_cpu_R8: assert property (@(posedge clk) disable iff (rst)
    (cyc >= 3'd4 && nmode && stop_cpu && $past(stop_cpu) && $past(stop_cpu, 2))
      |=> (clk_out[N_CPU-1:0] == '0));

  assert_align_R10: assert property (@(posedge clk) disable iff (rst)
    (tcyc >= 2'd3 && !$stable(clk_out[N_CPU])) |-> !$stable(clk_out[0]));
endmodule

bind clkout_stage clkout_stage_chk #(
  .N_CPU(N_CPU), .N_PCI(N_PCI), .N_SDR(N_SDR), .N_AGP(N_AGP)
) u_chk (
  .clk(clk), .rst(rst), .fsel(fsel), .sel1(sel1), .en(en),
  .stop_cpu(stop_cpu), .pdn(pdn), .clk_out(clk_out), .clk_oe(clk_oe)
);

// File: tb/clkout_stage_tb.sv
module clkout_stage_tb;
  localparam int NO = 25;

  logic          clk = 1'b0;
  logic          rst;
  logic [1:0]    fsel;
  logic          sel1, stop_cpu, stop_pci, pdn, tclk;
  logic [NO-1:0] en;
  logic [6:0]    src_clk;
  logic [NO-1:0] clk_out, clk_oe;
  logic          tclk_run;
  int            n_chk = 0, n_err = 0;
  bit            done = 0;

  always #2 clk = ~clk;

  clkout_stage u_dut (
    .clk(clk), .rst(rst), .fsel(fsel), .sel1(sel1), .en(en),
    .stop_cpu(stop_cpu), .stop_pci(stop_pci), .pdn(pdn),
    .src_clk(src_clk), .tclk(tclk), .clk_out(clk_out), .clk_oe(clk_oe)
  );

  typedef struct packed {
    logic [1:0]    fs;
    logic          s1, sc, sp, pd;
    logic [NO-1:0] en;
    logic [NO-1:0] eo;
    logic [NO-1:0] eoe;
  } vec_t;

  // Output layout: CPU[3:0] PCI[7:4] PCIF[8] SDR[20:9] USB[21] AGP[23:22] REF[24]
  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 25'h1FFFFFF, 25'h1FFFFFF, 25'h1FFFFFF},
    '{2'b00, 1'b0, 1'b1, 1'b0, 1'b0, 25'h1FFFFFF, 25'h1FFFFF0, 25'h1FFFFFF},
    '{2'b00, 1'b0, 1'b0, 1'b1, 1'b0, 25'h1FFFFFF, 25'h1FFFF0F, 25'h1FFFFFF},
    '{2'b00, 1'b0, 1'b1, 1'b1, 1'b0, 25'h1FFFFFF, 25'h1FFFF00, 25'h1FFFFFF},
    '{2'b00, 1'b0, 1'b0, 1'b0, 1'b1, 25'h1FFFFFF, 25'h0000000, 25'h1FFFFFF},
    '{2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 25'h0F0F0F0, 25'h0F0F0F0, 25'h1FFFFFF},
    '{2'b10, 1'b0, 1'b0, 1'b0, 1'b0, 25'h1555555, 25'h1555555, 25'h1FFFFFF},
    '{2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 25'h1FFFFFF, 25'h0000000, 25'h0000000},
    '{2'b01, 1'b1, 1'b1, 1'b0, 1'b0, 25'h1FFFFFF, 25'h1FFFFF0, 25'h1FFFFFF},
    '{2'b11, 1'b0, 1'b1, 1'b1, 1'b1, 25'h1FFFFFF, 25'h0000000, 25'h0000000},
    '{2'b00, 1'b0, 1'b0, 1'b1, 1'b0, 25'h0000100, 25'h0000100, 25'h1FFFFFF}
  };
  localparam string TAGS [NV] = '{
    "R7", "R8", "R8", "R8", "R9", "R7", "R6", "R1", "R5", "R1", "R8"
  };

  task automatic check(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  initial begin
    tclk = 1'b0;
    forever begin
      repeat (3) @(negedge clk);
      if (tclk_run) tclk = ~tclk;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  task automatic count_rises(input int idx, input int ncyc, output int n);
    logic prev;
    n = 0;
    prev = clk_out[idx];
    for (int c = 0; c < ncyc; c++) begin
      @(negedge clk);
      if (clk_out[idx] && !prev) n++;
      prev = clk_out[idx];
    end
  endtask

  initial begin
    int nr [7];
    rst = 1'b1; fsel = 2'b00; sel1 = 1'b0; en = '1;
    stop_cpu = 1'b0; stop_pci = 1'b0; pdn = 1'b0; src_clk = '1;
    tclk_run = 1'b0;
    repeat (4) @(negedge clk);
    // R11: reset state
    check(clk_out == '0, "R11 out", 32'(clk_out), 0);
    check(clk_oe == '0, "R11 oe", 32'(clk_oe), 0);
    rst = 1'b0;

    for (int v = 0; v < NV; v++) begin
      fsel = VECS[v].fs; sel1 = VECS[v].s1; stop_cpu = VECS[v].sc;
      stop_pci = VECS[v].sp; pdn = VECS[v].pd; en = VECS[v].en;
      repeat (6) @(negedge clk);
      check(clk_out == VECS[v].eo, TAGS[v], 32'(clk_out), 32'(VECS[v].eo));
      check(clk_oe == VECS[v].eoe, TAGS[v], 32'(clk_oe), 32'(VECS[v].eoe));
    end

    // R12: one-cycle source path and three-cycle stop path
    fsel = 2'b00; sel1 = 1'b0; en = '1; stop_cpu = 1'b0; stop_pci = 1'b0; pdn = 1'b0;
    repeat (6) @(negedge clk);
    src_clk[0] = 1'b0;
    @(negedge clk);
    check(clk_out[3:0] == 4'h0 && clk_out[4], "R12 src", 32'(clk_out), 32'h1FFFFF0);
    src_clk[0] = 1'b1;
    @(negedge clk);
    stop_cpu = 1'b1;
    repeat (2) @(negedge clk);
    check(clk_out[3:0] == 4'hF, "R12 stop early", 32'(clk_out[3:0]), 32'hF);
    @(negedge clk);
    check(clk_out[3:0] == 4'h0, "R12 stop", 32'(clk_out[3:0]), 32'h0);
    stop_cpu = 1'b0;

    // R2 R3 R4 R10: test mode with gating that must be ignored
    en = '0; stop_cpu = 1'b1; stop_pci = 1'b1; pdn = 1'b1;
    fsel = 2'b01; sel1 = 1'b0; tclk_run = 1'b1;
    repeat (30) @(negedge clk);
    fork
      count_rises(0,  288, nr[0]);
      count_rises(4,  288, nr[1]);
      count_rises(8,  288, nr[2]);
      count_rises(9,  288, nr[3]);
      count_rises(21, 288, nr[4]);
      count_rises(22, 288, nr[5]);
      count_rises(24, 288, nr[6]);
    join
    check(nr[0] >= 23 && nr[0] <= 25, "R2 cpu", 32'(nr[0]), 24);
    check(nr[3] >= 23 && nr[3] <= 25, "R2 sdr", 32'(nr[3]), 24);
    check(nr[4] >= 23 && nr[4] <= 25, "R2 usb", 32'(nr[4]), 24);
    check(nr[5] >= 23 && nr[5] <= 25, "R2 agp", 32'(nr[5]), 24);
    check(nr[1] >= 11 && nr[1] <= 13, "R3 pci", 32'(nr[1]), 12);
    check(nr[2] >= 11 && nr[2] <= 13, "R3 pcif", 32'(nr[2]), 12);
    check(nr[6] >= 47 && nr[6] <= 49, "R4 ref", 32'(nr[6]), 48);
    check(clk_oe == '1, "R10 oe", 32'(clk_oe), 32'h1FFFFFF);

    // R5 with a live test clock: sel1 high blocks test mode
    sel1 = 1'b1; pdn = 1'b0; stop_cpu = 1'b0; stop_pci = 1'b0; en = '1;
    repeat (6) @(negedge clk);
    count_rises(0, 60, nr[0]);
    check(nr[0] == 0 && clk_out == '1, "R5 live", 32'(clk_out), 32'h1FFFFFF);
    tclk_run = 1'b0;

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule